// File: doc/BRIEF.md
# Instruction Prefix Byte Scanner

This block sits at the head of an instruction decode path. It takes instruction bytes one per cycle through a valid/ready handshake. It consumes the leading legacy prefix bytes and stops at the first byte that is not one. At that point it issues a one-cycle summary with these fields:

- the operand-size and address-size override flags
- the segment that was selected
- the lock flag
- the repeat kind
- a conflict flag, raised when two prefixes of one group were seen
- the offset of the terminating byte
- the terminating byte itself, so that a following stage (for example the one handling the 64-bit register-extension byte) can pick it up

The prefix bytes fall into five exclusive groups: operand size, address size, segment, lock and repeat. They may appear in any order. A mode input says whether the processor runs in 64-bit mode. In that mode the four classic segment overrides have no effect, while the two extra data segments still apply. A long run of prefixes is cut off by a maximum count, so the scanner cannot hang.

Top module: `prefix_scanner`

## Requirements
- R1: The bytes 66h, 67h, 26h, 2Eh, 36h, 3Eh, 64h, 65h, F0h, F2h and F3h are prefixes. Every other byte ends the scan, and sum_offset then equals the number of prefix bytes that were accepted before it.
- R2: The clock edge that accepts a terminating byte makes sum_valid high for exactly one cycle, with sum_byte equal to that byte. sum_valid is low in every other cycle.
- R3: sum_opsize is 1 when a 66h byte was in the scan. sum_addrsize is 1 when a 67h byte was in the scan.
- R4: sum_seg reports the last effective segment prefix, coded as 0 none, 1 26h, 2 2Eh, 3 36h, 4 3Eh, 5 64h, 6 65h.
- R5: A byte of 26h, 2Eh, 36h or 3Eh accepted while mode64 is 1 leaves sum_seg unchanged. A 64h or 65h byte still takes effect in that mode.
- R6: sum_lock is 1 when an F0h byte was in the scan. sum_rep reports the last repeat prefix, coded as 0 none, 1 F3h, 2 F2h.
- R7: sum_conflict is 1 when any group received two or more prefix bytes, including repeats of the same byte and segment bytes ignored under R5. The conflicting group then reports its last byte.
- R8: A prefix byte that arrives after MAX_PFX (14) prefixes is consumed and aborts the scan. It produces a summary with sum_overflow 1, sum_offset 14 and fields covering the first 14 prefixes.
- R9: A synchronous reset clears all scan state and every summary output, and holds in_ready low. Outside reset, in_ready is high.
- R10: A new scan begins on the byte after a completed or aborted scan, and no prefix state carries into it.
- R11: A cycle with in_valid low neither advances nor ends a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be accepted |
| mode64 | input | 1 | Processor is in 64-bit mode |
| sum_valid | output | 1 | Summary pulse |
| sum_opsize | output | 1 | Operand-size override seen |
| sum_addrsize | output | 1 | Address-size override seen |
| sum_seg | output | 3 | Selected segment code |
| sum_lock | output | 1 | Lock prefix seen |
| sum_rep | output | 2 | Repeat kind code |
| sum_conflict | output | 1 | Two prefixes of one group |
| sum_overflow | output | 1 | Scan aborted by prefix limit |
| sum_offset | output | 4 | Offset of terminating byte |
| sum_byte | output | 8 | Terminating byte |

## Verification
Group state sits hidden until a scan ends, so a wrong internal state shows up in the summary one cycle after the terminating byte. It shows as a wrong flag, a wrong segment or repeat code, a missing conflict, or a wrong offset. A state that fails to clear after a summary shows in the next scan's summary, which is why the scenarios run scans back to back. A counter fault shows either as a wrong offset or as an overflow pulse at the wrong byte count. The bench therefore mixes short scans, scans at the limit and scans one byte past the limit.

// File: rtl/prefix_scan_pkg.sv
package prefix_scan_pkg;
  localparam int unsigned NUM_GRP = 5;

  typedef enum logic [2:0] {
    G_OSZ = 3'd0,
    G_ASZ = 3'd1,
    G_SEG = 3'd2,
    G_LCK = 3'd3,
    G_REP = 3'd4
  } grp_e;

  typedef logic [2:0] seg_t;
  typedef logic [1:0] rep_t;

  localparam seg_t SEG_NONE = 3'd0;
  localparam seg_t SEG_ES   = 3'd1;
  localparam seg_t SEG_CS   = 3'd2;
  localparam seg_t SEG_SS   = 3'd3;
  localparam seg_t SEG_DS   = 3'd4;
  localparam seg_t SEG_FS   = 3'd5;
  localparam seg_t SEG_GS   = 3'd6;

  localparam rep_t REP_NONE = 2'd0;
  localparam rep_t REP_EQ   = 2'd1;
  localparam rep_t REP_NE   = 2'd2;

  typedef struct packed {
    logic hit;
    grp_e grp;
    seg_t seg;
    rep_t rep;
  } pfx_cls_t;

  function automatic pfx_cls_t classify_byte(input logic [7:0] b);
    pfx_cls_t c;
    c = '{hit: 1'b1, grp: G_OSZ, seg: SEG_NONE, rep: REP_NONE};
    case (b)
      8'h66: c.grp = G_OSZ;
      8'h67: c.grp = G_ASZ;
      8'h26: begin c.grp = G_SEG; c.seg = SEG_ES; end
      8'h2E: begin c.grp = G_SEG; c.seg = SEG_CS; end
      8'h36: begin c.grp = G_SEG; c.seg = SEG_SS; end
      8'h3E: begin c.grp = G_SEG; c.seg = SEG_DS; end
      8'h64: begin c.grp = G_SEG; c.seg = SEG_FS; end
      8'h65: begin c.grp = G_SEG; c.seg = SEG_GS; end
      8'hF0: c.grp = G_LCK;
      8'hF3: begin c.grp = G_REP; c.rep = REP_EQ; end
      8'hF2: begin c.grp = G_REP; c.rep = REP_NE; end
      default: c.hit = 1'b0;
    endcase
    return c;
  endfunction

  function automatic logic seg_dropped_in_long(input seg_t s);
    return (s == SEG_ES) || (s == SEG_CS) || (s == SEG_SS) || (s == SEG_DS);
  endfunction
endpackage

// File: rtl/pfx_classifier.sv
module pfx_classifier
  import prefix_scan_pkg::*;
(
  input  logic [7:0]         byte_in,
  output pfx_cls_t           cls,
  output logic [NUM_GRP-1:0] grp_hot
);
  assign cls = classify_byte(byte_in);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_hot
    assign grp_hot[g] = cls.hit && (cls.grp == grp_e'(g));
  end
endmodule

// File: rtl/pfx_group_tracker.sv
module pfx_group_tracker
  import prefix_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               take,
  input  logic               mode64,
  input  pfx_cls_t           cls,
  input  logic [NUM_GRP-1:0] grp_hot,
  output logic               dup,
  output logic               conf,
  output logic               osz,
  output logic               asz,
  output seg_t               seg,
  output logic               lock,
  output rep_t               rep
);
  logic [NUM_GRP-1:0] seen_q, seen_nxt;

  assign dup = |(grp_hot & seen_q);

  always_comb begin
    seen_nxt = seen_q;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (take && grp_hot[g]) seen_nxt[g] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q <= '0;
      conf   <= 1'b0;
      osz    <= 1'b0;
      asz    <= 1'b0;
      seg    <= SEG_NONE;
      lock   <= 1'b0;
      rep    <= REP_NONE;
    end else if (take) begin
      seen_q <= seen_nxt;
      if (dup) conf <= 1'b1;
      case (cls.grp)
        G_OSZ: osz <= 1'b1;
        G_ASZ: asz <= 1'b1;
        G_SEG: if (!(mode64 && seg_dropped_in_long(cls.seg))) seg <= cls.seg;
        G_LCK: lock <= 1'b1;
        G_REP: rep <= cls.rep;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pfx_scan_counter.sv
module pfx_scan_counter #(
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned CNT_W  = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max
);
  assign at_max = (cnt == CNT_W'(MAX_PFX));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (inc)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prefix_scanner.sv
module prefix_scanner
  import prefix_scan_pkg::*;
#(
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned CNT_W  = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  input  logic             mode64,
  output logic             sum_valid,
  output logic             sum_opsize,
  output logic             sum_addrsize,
  output logic [2:0]       sum_seg,
  output logic             sum_lock,
  output logic [1:0]       sum_rep,
  output logic             sum_conflict,
  output logic             sum_overflow,
  output logic [CNT_W-1:0] sum_offset,
  output logic [7:0]       sum_byte
);
  pfx_cls_t           cls;
  logic [NUM_GRP-1:0] grp_hot;
  logic               accept, take, end_evt, over_evt, fin_evt;
  logic               dup, trk_conf, trk_osz, trk_asz, trk_lock, at_max;
  seg_t               trk_seg;
  rep_t               trk_rep;
  logic [CNT_W-1:0]   cnt;

  assign in_ready = !rst;
  assign accept   = in_valid && in_ready;
  assign take     = accept && cls.hit && !at_max;
  assign over_evt = accept && cls.hit && at_max;
  assign end_evt  = accept && !cls.hit;
  assign fin_evt  = end_evt || over_evt;

  pfx_classifier u_cls (
    .byte_in (in_data),
    .cls     (cls),
    .grp_hot (grp_hot)
  );

  pfx_group_tracker u_trk (
    .clk     (clk),
    .rst     (rst),
    .clear   (fin_evt),
    .take    (take),
    .mode64  (mode64),
    .cls     (cls),
    .grp_hot (grp_hot),
    .dup     (dup),
    .conf    (trk_conf),
    .osz     (trk_osz),
    .asz     (trk_asz),
    .seg     (trk_seg),
    .lock    (trk_lock),
    .rep     (trk_rep)
  );

  pfx_scan_counter #(.MAX_PFX(MAX_PFX)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear  (fin_evt),
    .inc    (take),
    .cnt    (cnt),
    .at_max (at_max)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid    <= 1'b0;
      sum_opsize   <= 1'b0;
      sum_addrsize <= 1'b0;
      sum_seg      <= SEG_NONE;
      sum_lock     <= 1'b0;
      sum_rep      <= REP_NONE;
      sum_conflict <= 1'b0;
      sum_overflow <= 1'b0;
      sum_offset   <= '0;
      sum_byte     <= '0;
    end else begin
      sum_valid <= fin_evt;
      if (fin_evt) begin
        sum_opsize   <= trk_osz;
        sum_addrsize <= trk_asz;
        sum_seg      <= trk_seg;
        sum_lock     <= trk_lock;
        sum_rep      <= trk_rep;
        sum_conflict <= trk_conf;
        sum_overflow <= over_evt;
        sum_offset   <= cnt;
        sum_byte     <= in_data;
      end
    end
  end
endmodule

// File: rtl/prefix_scan_checker.sv
module prefix_scan_checker
  import prefix_scan_pkg::*;
#(
  parameter int unsigned MAX_PFX = 14,
  localparam int unsigned CNT_W  = $clog2(MAX_PFX + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             mode64,
  input logic             end_evt,
  input logic             take,
  input logic             dup,
  input pfx_cls_t         cls,
  input seg_t             trk_seg,
  input logic             trk_conf,
  input logic             sum_valid,
  input logic             sum_overflow,
  input logic [CNT_W-1:0] sum_offset,
  input logic [1:0]       sum_rep
);
  assert_summary_after_stop_R2: assert property (@(posedge clk) disable iff (rst)
    end_evt |=> (sum_valid && !sum_overflow));

  assert_idle_no_summary_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !sum_valid);

  assert_offset_bound_R1: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (sum_offset <= CNT_W'(MAX_PFX)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (sum_valid && sum_overflow) |-> (sum_offset == CNT_W'(MAX_PFX)));

  assert_long_seg_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (take && mode64 && cls.grp == G_SEG && seg_dropped_in_long(cls.seg)) |=> $stable(trk_seg));

  assert_conflict_raised_R7: assert property (@(posedge clk) disable iff (rst)
    (take && dup) |=> trk_conf);

  assert_rep_code_R6: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (sum_rep != 2'd3));
endmodule

bind prefix_scanner prefix_scan_checker #(.MAX_PFX(MAX_PFX)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .mode64       (mode64),
  .end_evt      (end_evt),
  .take         (take),
  .dup          (dup),
  .cls          (cls),
  .trk_seg      (trk_seg),
  .trk_conf     (trk_conf),
  .sum_valid    (sum_valid),
  .sum_overflow (sum_overflow),
  .sum_offset   (sum_offset),
  .sum_rep      (sum_rep)
);

// File: tb/prefix_scanner_test.sv
`timescale 1ns/1ps
module prefix_scanner_test;
  localparam int MAXP = 14;

  logic clk = 1'b0;
  logic rst, in_valid, mode64, in_ready;
  logic [7:0] in_data;
  logic sum_valid, sum_opsize, sum_addrsize, sum_lock, sum_conflict, sum_overflow;
  logic [2:0] sum_seg;
  logic [1:0] sum_rep;
  logic [3:0] sum_offset;
  logic [7:0] sum_byte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  byte unsigned pq[$];
  bit mq[$];
  bit e_valid, e_osz, e_asz, e_lock, e_conf, e_over, e_m64;
  int e_seg, e_rep, e_off, e_byte;
  string vtag = "R2";

  always #2.5 clk = ~clk;

  prefix_scanner uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mode64(mode64), .sum_valid(sum_valid), .sum_opsize(sum_opsize),
    .sum_addrsize(sum_addrsize), .sum_seg(sum_seg), .sum_lock(sum_lock),
    .sum_rep(sum_rep), .sum_conflict(sum_conflict), .sum_overflow(sum_overflow),
    .sum_offset(sum_offset), .sum_byte(sum_byte)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_prefix(input byte unsigned b);
    return b == 8'h66 || b == 8'h67 || b == 8'h26 || b == 8'h2E || b == 8'h36 ||
           b == 8'h3E || b == 8'h64 || b == 8'h65 || b == 8'hF0 || b == 8'hF2 || b == 8'hF3;
  endfunction

  task automatic finish_scan(input byte unsigned stop, input bit over);
    int cnt[5];
    cnt = '{0, 0, 0, 0, 0};
    e_osz = 0; e_asz = 0; e_lock = 0; e_seg = 0; e_rep = 0; e_m64 = 0;
    foreach (pq[i]) begin
      int code;
      code = 0;
      case (pq[i])
        8'h66: begin e_osz = 1; cnt[0]++; end
        8'h67: begin e_asz = 1; cnt[1]++; end
        8'hF0: begin e_lock = 1; cnt[3]++; end
        8'hF3: begin e_rep = 1; cnt[4]++; end
        8'hF2: begin e_rep = 2; cnt[4]++; end
        8'h26: code = 1;
        8'h2E: code = 2;
        8'h36: code = 3;
        8'h3E: code = 4;
        8'h64: code = 5;
        8'h65: code = 6;
        default: ;
      endcase
      if (code != 0) begin
        cnt[2]++;
        if (mq[i]) e_m64 = 1;
        if (!(mq[i] && code <= 4)) e_seg = code;
      end
    end
    e_conf = 0;
    foreach (cnt[g]) if (cnt[g] > 1) e_conf = 1;
    e_off = pq.size();
    e_byte = stop;
    e_over = over;
    e_valid = 1;
    pq.delete();
    mq.delete();
  endtask

  task automatic compare();
    chk(vtag, "sum_valid", sum_valid, e_valid);
    if (e_valid && sum_valid) begin
      chk("R1", "offset", sum_offset, e_off);
      chk("R2", "stop byte", sum_byte, e_byte);
      chk("R3", "opsize", sum_opsize, e_osz);
      chk("R3", "addrsize", sum_addrsize, e_asz);
      chk(e_m64 ? "R5" : "R4", "segment", sum_seg, e_seg);
      chk("R6", "lock", sum_lock, e_lock);
      chk("R6", "repeat", sum_rep, e_rep);
      chk("R7", "conflict", sum_conflict, e_conf);
      chk("R8", "overflow", sum_overflow, e_over);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input byte unsigned d, input bit m);
    bit rdy;
    in_valid = v; in_data = d; mode64 = m;
    #0.1;
    rdy = in_ready;
    @(posedge clk);
    e_valid = 0;
    if (rst) begin
      pq.delete(); mq.delete();
    end else if (v && rdy) begin
      if (is_prefix(d) && pq.size() < MAXP) begin
        pq.push_back(d); mq.push_back(m);
      end else begin
        finish_scan(d, is_prefix(d));
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic send(input byte unsigned bs[], input bit m);
    foreach (bs[i]) step(1'b1, bs[i], m);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    rst = 1; in_valid = 0; in_data = 8'h00; mode64 = 0;
    @(negedge clk);
    step(1'b1, 8'h66, 1'b0);
    chk("R9", "in_ready during reset", in_ready, 0);
    rst = 0;
    #0.1;
    chk("R9", "in_ready after reset", in_ready, 1);
    chk("R9", "reset summary fields", {sum_opsize, sum_addrsize, sum_seg, sum_lock,
        sum_rep, sum_conflict, sum_overflow, sum_offset, sum_byte}, 0);

    send('{8'h90}, 0);                                   // R1 no prefix
    send('{8'h66, 8'h67, 8'h8B}, 0);                     // R3
    send('{8'h67, 8'h66, 8'h48}, 0);                     // R1 register-extension byte ends scan
    send('{8'h26, 8'h89}, 0);                            // R4 each code
    send('{8'h2E, 8'h89}, 0);
    send('{8'h36, 8'h89}, 0);
    send('{8'h3E, 8'h89}, 0);
    send('{8'h64, 8'h89}, 0);
    send('{8'h65, 8'h89}, 0);
    send('{8'h2E, 8'h89}, 1);                            // R5 dropped
    send('{8'h64, 8'h89}, 1);                            // R5 kept
    send('{8'h65, 8'h3E, 8'h89}, 1);                     // R5 + R7
    send('{8'hF0, 8'hF3, 8'hA4}, 0);                     // R6
    send('{8'hF2, 8'hAE}, 0);
    send('{8'hF3, 8'hF2, 8'hAE}, 0);                     // R7 last wins
    send('{8'h66, 8'h66, 8'h01}, 0);                     // R7 same byte twice
    send('{8'h2E, 8'h36, 8'h01}, 0);                     // R7 seg last wins

    vtag = "R11";
    step(1'b1, 8'h66, 0);
    step(1'b0, 8'h90, 0);
    step(1'b0, 8'h90, 0);
    step(1'b1, 8'h67, 0);
    step(1'b0, 8'h01, 0);
    step(1'b1, 8'h90, 0);

    vtag = "R8";
    for (int i = 0; i < 15; i++) step(1'b1, 8'h66, 0);   // 15th aborts
    vtag = "R10";
    send('{8'h90}, 0);                                   // fresh scan
    for (int i = 0; i < 14; i++) step(1'b1, 8'hF0, 0);   // exactly at limit
    send('{8'h0F}, 0);

    send('{8'h66, 8'h67, 8'hF3}, 0);                     // reset mid-scan
    rst = 1;
    step(1'b0, 8'h00, 0);
    rst = 0;
    vtag = "R9";
    send('{8'h65, 8'h90}, 0);
    vtag = "R10";
    send('{8'hF2, 8'hC3, 8'h90}, 0);                     // back to back
    step(1'b0, 8'h00, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule